// File: doc/BRIEF.md
# Preloadable Up-Counting Interval Timer

This block is a periodic interval timer built around a 16-bit up-counter. A single-cycle tick enable, generated elsewhere at a fixed 160 kHz, advances the counter. The counter starts from a software-loaded preload value and climbs towards 0xFFFF. When it passes 0xFFFF, it takes the preload value again in that same tick, a saturating 4-bit overflow tally counts up, and an interrupt becomes pending. For a desired rate f, software loads the preload with 0x10000 minus 160000/f.

Software drives the timer through a small byte-or-halfword register bus. A 3-bit code in the control byte selects one of four states: clear, clock enabled but idle, stopped with count held, and running. A separate interrupt control byte holds an enable bit, a 3-bit request level and a pending flag that software acknowledges by writing 1 to it. The request output carries the programmed level while an enabled interrupt is pending and is zero otherwise.

Top module: `ivtimer`

## Requirements
- R1: After reset the preload, count, control byte and interrupt control byte all read 0, and irq_level is 0.
- R2: Byte offsets are: preload halfword at 0, count halfword at 2, control byte at 4, interrupt control byte at 5. Halfword accesses use bus_wdata/bus_rdata[15:0], and the even byte is the high byte. Byte writes take bus_wdata[7:0]. A byte read returns its byte in bus_rdata[7:0] with bits 15:8 zero. Read data appears on the cycle after bus_rd.
- R3: With control code 3'b111 (run) in bits 2:0, the count rises by one on each cycle where tick is high. A tick at count 0xFFFF loads the preload value in that same tick, so the count never passes through 0.
- R4: Control bits 7:4 hold the overflow tally. The tally increases by one on each wrap and stays at 15 once it gets there. Writes to bits 7:4 have no effect, and bit 3 reads 0.
- R5: Control codes 3'b011 (stop) and 3'b001 (enable) hold the count and the tally across ticks.
- R6: Writing control code 3'b000 clears the count and the tally. The counter then stays at 0 across ticks.
- R7: Without a tick, the count does not change, even in the run state.
- R8: In the interrupt control byte, bit 3 is enable, bits 2:0 are the level and bit 7 is pending. A wrap sets pending whether or not the interrupt is enabled. irq_level equals the level while pending and enable are both 1, and is 0 otherwise.
- R9: Writing the interrupt control byte with bit 7 = 1 clears pending, and a write with bit 7 = 0 leaves it alone. If a wrap falls in the same cycle as an acknowledge, pending stays set.
- R10: A software write to the count in a cycle with a tick takes priority: the written value is kept, and that tick neither advances the count nor wraps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 160 kHz count enable, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_level | output | 3 | Requested interrupt level, 0 when no request |

## Verification
Two pairs of events can land in the same cycle: a wrap with a software acknowledge of the pending flag, and a tick with a software write to the count. The bench provokes each pair by raising tick in the very cycle that carries the bus write. The first case uses a timer that wraps on every tick (preload and count both 0xFFFF). The pass condition is that pending reads back as set and the request level is still driven. For the second case, the count must read back exactly the written value, and the next tick must move it up by one.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 16;
  localparam int TALLY_W = 4;
  localparam int LVL_W  = 3;
  localparam int CODE_W = 3;
  localparam int NUM_HW = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_CLEAR  = 3'b000,
    CODE_ENABLE = 3'b001,
    CODE_STOP   = 3'b011,
    CODE_RUN    = 3'b111
  } ctl_code_e;

  localparam int HW_PRELOAD = 0;
  localparam int HW_COUNT   = 1;
  localparam int HW_CTRL    = 2;
endpackage

// File: rtl/ivt_regif.sv
module ivt_regif #(
  parameter int ADDR_W = ivt_pkg::ADDR_W,
  parameter int BUS_W  = ivt_pkg::CNT_W,
  parameter int NUM_HW = ivt_pkg::NUM_HW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic                    bus_half,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  input  logic [NUM_HW*BUS_W-1:0] rd_words,
  output logic [NUM_HW-1:0]       hi_we,
  output logic [NUM_HW-1:0]       lo_we,
  output logic [BUS_W/2-1:0]      hi_data,
  output logic [BUS_W/2-1:0]      lo_data,
  output logic [BUS_W-1:0]        bus_rdata
);
  localparam int BYTE_W = BUS_W / 2;
  localparam int IDX_W  = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic [BUS_W-1:0] sel_word;
  logic [BUS_W-1:0] rdata_q;

  assign idx = bus_addr[ADDR_W-1:1];

  // even byte is the high byte of its halfword
  genvar gi;
  generate
    for (gi = 0; gi < NUM_HW; gi++) begin : g_strobe
      assign hi_we[gi] = bus_wr && (idx == IDX_W'(gi)) && (bus_half || !bus_addr[0]);
      assign lo_we[gi] = bus_wr && (idx == IDX_W'(gi)) && (bus_half ||  bus_addr[0]);
    end
  endgenerate

  assign hi_data = bus_half ? bus_wdata[BUS_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
  assign lo_data = bus_wdata[BYTE_W-1:0];

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_HW; i++) begin
      if (idx == IDX_W'(i)) sel_word = rd_words[i*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (bus_half)
        rdata_q <= sel_word;
      else if (bus_addr[0])
        rdata_q <= {{BYTE_W{1'b0}}, sel_word[BYTE_W-1:0]};
      else
        rdata_q <= {{BYTE_W{1'b0}}, sel_word[BUS_W-1:BYTE_W]};
    end
  end

  assign bus_rdata = rdata_q;

  // a write touches at most one halfword slot
  p_one_slot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hi_we | lo_we));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W   = ivt_pkg::CNT_W,
  parameter int TALLY_W = ivt_pkg::TALLY_W,
  parameter int CODE_W  = ivt_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               pre_hi_we,
  input  logic               pre_lo_we,
  input  logic               cnt_hi_we,
  input  logic               cnt_lo_we,
  input  logic               ctl_we,
  input  logic [CNT_W/2-1:0] hi_data,
  input  logic [CNT_W/2-1:0] lo_data,
  output logic [CNT_W-1:0]   preload_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CODE_W-1:0]  code_o,
  output logic [TALLY_W-1:0] tally_o,
  output logic               wrap_o
);
  import ivt_pkg::*;
  localparam int BYTE_W = CNT_W / 2;
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

  logic [CNT_W-1:0]   preload_q, count_q, count_d;
  logic [TALLY_W-1:0] tally_q, tally_d;
  logic [CODE_W-1:0]  code_q;
  logic               run, wr_cnt, clr, wrap;

  assign run    = (code_q == CODE_RUN);
  assign wr_cnt = cnt_hi_we || cnt_lo_we;
  assign clr    = ctl_we && (hi_data[CODE_W-1:0] == CODE_CLEAR);
  assign wrap   = tick && run && (count_q == CNT_MAX) && !wr_cnt && !clr;

  always_comb begin
    count_d = count_q;
    if (clr) begin
      count_d = '0;
    end else if (wr_cnt) begin
      if (cnt_hi_we) count_d[CNT_W-1:BYTE_W] = hi_data;
      if (cnt_lo_we) count_d[BYTE_W-1:0]     = lo_data;
    end else if (tick && run) begin
      count_d = wrap ? preload_q : count_q + 1'b1;
    end
  end

  always_comb begin
    tally_d = tally_q;
    if (clr)
      tally_d = '0;
    else if (wrap && tally_q != TALLY_MAX)
      tally_d = tally_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= '0;
      count_q   <= '0;
      tally_q   <= '0;
      code_q    <= CODE_CLEAR;
    end else begin
      if (pre_hi_we) preload_q[CNT_W-1:BYTE_W] <= hi_data;
      if (pre_lo_we) preload_q[BYTE_W-1:0]     <= lo_data;
      if (ctl_we)    code_q <= hi_data[CODE_W-1:0];
      count_q <= count_d;
      tally_q <= tally_d;
    end
  end

  assign preload_o = preload_q;
  assign count_o   = count_q;
  assign code_o    = code_q;
  assign tally_o   = tally_q;
  assign wrap_o    = wrap;

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> count_q == $past(preload_q));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt && !clr) |=> ($stable(count_q) && $stable(tally_q)));
  p_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (tally_q == TALLY_MAX && !clr) |=> tally_q == TALLY_MAX);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0 && tally_q == '0));
  p_notick_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt && !clr) |=> ($stable(count_q) && $stable(tally_q)));
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
  parameter int LVL_W  = ivt_pkg::LVL_W,
  parameter int BYTE_W = ivt_pkg::CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  input  logic              icr_we,
  input  logic [BYTE_W-1:0] icr_data,
  output logic [BYTE_W-1:0] icr_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  localparam int PAD_W = BYTE_W - 2 - LVL_W;
  localparam int EN_B  = LVL_W;

  logic             pend_q, pend_d, en_q, en_d;
  logic [LVL_W-1:0] lvl_q, lvl_d, irq_q;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    lvl_d  = lvl_q;
    if (icr_we) begin
      en_d  = icr_data[EN_B];
      lvl_d = icr_data[LVL_W-1:0];
      if (icr_data[BYTE_W-1]) pend_d = 1'b0;
    end
    if (wrap_i) pend_d = 1'b1;  // new event beats acknowledge
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      lvl_q  <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      irq_q  <= (pend_d && en_d) ? lvl_d : '0;
    end
  end

  assign icr_o       = {pend_q, {PAD_W{1'b0}}, en_q, lvl_q};
  assign irq_level_o = irq_q;

  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_level_o != '0) |-> (pend_q && en_q));
  p_level_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && en_q) |-> (irq_level_o == lvl_q));
  p_setwins_r9: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> pend_q);
  p_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (icr_we && icr_data[BYTE_W-1] && !wrap_i) |=> !pend_q);
endmodule

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int ADDR_W  = ivt_pkg::ADDR_W,
  parameter int CNT_W   = ivt_pkg::CNT_W,
  parameter int TALLY_W = ivt_pkg::TALLY_W,
  parameter int LVL_W   = ivt_pkg::LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]  irq_level
);
  import ivt_pkg::*;
  localparam int BYTE_W  = CNT_W / 2;
  localparam int NHW     = ivt_pkg::NUM_HW;
  localparam int CPAD_W  = BYTE_W - TALLY_W - CODE_W;

  logic [NHW-1:0]       hi_we, lo_we;
  logic [BYTE_W-1:0]    hi_data, lo_data, ctl_byte, icr_byte;
  logic [CNT_W-1:0]     preload, count;
  logic [CODE_W-1:0]    code;
  logic [TALLY_W-1:0]   tally;
  logic                 wrap;
  logic [NHW*CNT_W-1:0] rd_words;

  assign ctl_byte = {tally, {CPAD_W{1'b0}}, code};
  assign rd_words = {ctl_byte, icr_byte, count, preload};

  ivt_regif #(.ADDR_W(ADDR_W), .BUS_W(CNT_W), .NUM_HW(NHW)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_words(rd_words),
    .hi_we(hi_we), .lo_we(lo_we), .hi_data(hi_data), .lo_data(lo_data),
    .bus_rdata(bus_rdata)
  );

  ivt_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .CODE_W(CODE_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick),
    .pre_hi_we(hi_we[HW_PRELOAD]), .pre_lo_we(lo_we[HW_PRELOAD]),
    .cnt_hi_we(hi_we[HW_COUNT]), .cnt_lo_we(lo_we[HW_COUNT]),
    .ctl_we(hi_we[HW_CTRL]), .hi_data(hi_data), .lo_data(lo_data),
    .preload_o(preload), .count_o(count), .code_o(code), .tally_o(tally),
    .wrap_o(wrap)
  );

  ivt_irq #(.LVL_W(LVL_W), .BYTE_W(BYTE_W)) u_irq (
    .clk(clk), .rst(rst), .wrap_i(wrap), .icr_we(lo_we[HW_CTRL]),
    .icr_data(lo_data), .icr_o(icr_byte), .irq_level_o(irq_level)
  );
endmodule

// File: tb/ivtimer_tb.sv
`timescale 1ns/1ps
module ivtimer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_half = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq_level;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ivtimer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_level(irq_level)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic half, logic [15:0] d, logic with_tick = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_half = half; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic half, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_half = half; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, 1, v); check("R1 preload", v, 16'h0000);
    rd(3'd2, 1, v); check("R1 count", v, 16'h0000);
    rd(3'd4, 0, v); check("R1 control", v, 16'h0000);
    rd(3'd5, 0, v); check("R1 irq ctrl", v, 16'h0000);
    check("R1 irq_level", {13'd0, irq_level}, 16'h0000);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(3'd0, 1, 16'h1234);
    rd(3'd0, 1, v); check("R2 halfword preload", v, 16'h1234);
    wr(3'd1, 0, 16'h00AB);
    rd(3'd0, 1, v); check("R2 odd byte write", v, 16'h12AB);
    rd(3'd0, 0, v); check("R2 even byte read", v, 16'h0012);
    rd(3'd1, 0, v); check("R2 odd byte read", v, 16'h00AB);
  endtask

  task automatic t_run();
    logic [15:0] v;
    wr(3'd0, 1, 16'hFF00);
    wr(3'd2, 1, 16'hFFFD);
    wr(3'd4, 0, 16'h0007);
    ticks(2);
    rd(3'd2, 1, v); check("R3 count up", v, 16'hFFFF);
    ticks(1);
    rd(3'd2, 1, v); check("R3 wrap reload", v, 16'hFF00);
    rd(3'd4, 0, v); check("R4 tally one", v, 16'h0017);
    wr(3'd4, 0, 16'h00F7);
    rd(3'd4, 0, v); check("R4 tally write ignored", v, 16'h0017);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    wr(3'd4, 0, 16'h0003);
    ticks(5);
    rd(3'd2, 1, v); check("R5 stop holds count", v, 16'hFF00);
    rd(3'd4, 0, v); check("R5 stop holds tally", v, 16'h0013);
    wr(3'd4, 0, 16'h0001);
    ticks(3);
    rd(3'd2, 1, v); check("R5 enable holds count", v, 16'hFF00);
    wr(3'd4, 0, 16'h0007);
    repeat (5) @(negedge clk);
    rd(3'd2, 1, v); check("R7 no tick no change", v, 16'hFF00);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(3'd4, 0, 16'h0000);
    rd(3'd2, 1, v); check("R6 count cleared", v, 16'h0000);
    rd(3'd4, 0, v); check("R6 tally cleared", v, 16'h0000);
    ticks(4);
    rd(3'd2, 1, v); check("R6 stays zero", v, 16'h0000);
  endtask

  task automatic t_swprec();
    logic [15:0] v;
    wr(3'd4, 0, 16'h0007);
    wr(3'd2, 1, 16'h0100, 1'b1);
    rd(3'd2, 1, v); check("R10 write beats tick", v, 16'h0100);
    ticks(1);
    rd(3'd2, 1, v); check("R10 next tick advances", v, 16'h0101);
  endtask

  task automatic t_sat();
    logic [15:0] v;
    wr(3'd4, 0, 16'h0000);
    wr(3'd0, 1, 16'hFFFF);
    wr(3'd2, 1, 16'hFFFF);
    wr(3'd4, 0, 16'h0007);
    ticks(20);
    rd(3'd4, 0, v); check("R4 tally saturates", v, 16'h00F7);
    rd(3'd2, 1, v); check("R3 reload every tick", v, 16'hFFFF);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    rd(3'd5, 0, v); check("R8 pending while disabled", v, 16'h0080);
    check("R8 no request when disabled", {13'd0, irq_level}, 16'h0000);
    wr(3'd5, 0, 16'h000D);
    rd(3'd5, 0, v); check("R9 zero bit7 keeps pending", v, 16'h008D);
    check("R8 level driven", {13'd0, irq_level}, 16'h0005);
    wr(3'd5, 0, 16'h008D);
    rd(3'd5, 0, v); check("R9 ack clears", v, 16'h000D);
    check("R9 request dropped", {13'd0, irq_level}, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(3'd5, 0, 16'h008D, 1'b1);
    rd(3'd5, 0, v); check("R9 wrap beats ack", v, 16'h008D);
    check("R9 level after collision", {13'd0, irq_level}, 16'h0005);
    wr(3'd5, 0, 16'h008D);
    rd(3'd5, 0, v); check("R9 later ack", v, 16'h000D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_run();
    t_hold();
    t_clear();
    t_swprec();
    t_sat();
    t_irq();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule